// File: doc/BRIEF.md
# Nibble-Wide Host Command Port

This block connects a host that only has a four-bit data path, a two-bit command code and one strobe wire to a byte-wide local memory port with an asynchronous-read, SRAM-style interface. The host selects a mode with the command code. It then moves one nibble across the bus each time it flips the strobe level. Both the rising and the falling level change count as a transfer.

In address mode the nibbles build up a memory address, least significant nibble first. In write mode, pairs of nibbles become bytes. Each byte is written to the current address, and the address then steps forward. In read mode the host releases the nibble bus. Each strobe flip then either fetches the byte at the current address and shows its low half, or shows the high half and advances the address. A busy output covers the clock in which a memory access is under way.

All host inputs are asynchronous to the block clock and pass through a two-stage synchronizer. A host action therefore reaches the memory port on the third rising clock edge after the strobe level changes. With a 20 ns clock, strobe flips may be spaced as close as three clocks.

Top module: `nhp_host_port`

## Requirements
- R1: While reset is held, and directly after it is released, the memory address output is zero and the following outputs are low: memory write strobe, memory read enable, busy, and the nibble bus drive enable.
- R2: With command code 01 (address load), each strobe level change stores the bus nibble into the address at nibble position 0, 1, 2, 3 in turn. Position 0 is address bits 3:0. The fourth nibble also clears address bit 16, and the next nibble starts again at position 0.
- R3: With command code 10 (write), the first strobe level change holds the bus nibble as the low half of a byte. The second level change supplies the high half, and the byte is written to the current address.
- R4: The memory write strobe is high for exactly one clock. That clock starts on the third rising edge after the strobe level change that completed the byte, and busy is high for that same clock.
- R5: After each written byte the address increases by one, carrying into bit 16. Consecutive bytes therefore go to consecutive addresses without a new address load.
- R6: With command code 11 (read), the level changes alternate. An even-numbered change reads the byte at the current address, with the memory read enable high for one clock, and drives its low nibble on the bus. The following change drives the high nibble and increases the address by one.
- R7: The block drives the nibble bus (drive enable high) only while the synchronized command code is 11. At all other times the drive enable is low and an external pad leaves the bus floating.
- R8: Any change of the command code returns the nibble position to zero. A half-assembled byte or address is then not continued.
- R9: With command code 00 (idle), strobe level changes have no effect on the address or on memory.
- R10: Strobe level changes spaced three clocks apart are all taken, including bursts of several write bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_i | input | 2 | Host command code: 00 idle, 01 address, 10 write, 11 read |
| strobe_i | input | 1 | Host strobe; every level change moves one nibble |
| nib_i | input | NIB_W | Nibble bus value from the pad |
| nib_o | output | NIB_W | Nibble driven toward the host in read mode |
| nib_oe | output | 1 | Pad drive enable for nib_o |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 2*NIB_W | Memory write byte |
| mem_rdata_i | input | 2*NIB_W | Memory read byte, valid in the read-enable clock |
| mem_we_o | output | 1 | Memory write strobe, one clock per byte |
| mem_oe_o | output | 1 | Memory read enable, one clock per fetch |
| busy_o | output | 1 | High while a memory access is in progress |

## Verification
A wrong nibble position or a missed level change shows up as a wrong address value within five clocks of the strobe flip, because the address register is visible at the port after every nibble. A stale low half or a missed count reset produces a wrong byte in memory on the next write strobe. A read pointer that is off by one shows up as a wrong nibble on the bus or a wrong address at the next read toggle. Write and read enables that last more than one clock, or that overlap, are flagged in the cycle after they occur.

// File: rtl/nhp_pkg.sv
package nhp_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_ADDR  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_READ  = 2'b11
  } nhp_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WRITE = 2'b01,
    ST_FETCH = 2'b10
  } nhp_state_e;

endpackage

// File: rtl/nhp_rst_sync.sv
module nhp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 2'b00;
    else        hold_q <= {hold_q[0], 1'b1};
  end

  assign rst_sync_n = hold_q[1];

endmodule

// File: rtl/nhp_sync.sv
module nhp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/nhp_front.sv
module nhp_front
  import nhp_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_i,
  input  logic             strobe_i,
  input  logic [NIB_W-1:0] nib_i,
  output nhp_cmd_e         cmd_s,
  output logic [NIB_W-1:0] nib_s,
  output logic             toggle,
  output logic             cmd_chg
);

  localparam int SW = NIB_W + 3;

  logic [SW-1:0] raw_bus;
  logic [SW-1:0] sync_bus;
  logic [1:0]    cmd_bits;
  logic          stb_s;

  assign raw_bus = {cmd_i, strobe_i, nib_i};

  nhp_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (sync_bus)
  );

  assign {cmd_bits, stb_s, nib_s} = sync_bus;
  assign cmd_s = nhp_cmd_e'(cmd_bits);

  logic       stb_prev_q, stb_prev_n;
  logic [1:0] cmd_prev_q, cmd_prev_n;

  always_comb begin
    stb_prev_n = stb_s;
    cmd_prev_n = cmd_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev_q <= 1'b0;
      cmd_prev_q <= 2'b00;
    end else begin
      stb_prev_q <= stb_prev_n;
      cmd_prev_q <= cmd_prev_n;
    end
  end

  assign toggle  = stb_s ^ stb_prev_q;
  assign cmd_chg = (cmd_bits != cmd_prev_q);

endmodule

// File: rtl/nhp_addr.sv
module nhp_addr #(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 4,
  parameter int ADDR_W    = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [NIB_W-1:0]  ld_nib,
  input  logic              ld_last,
  input  logic              inc_en,
  output logic [ADDR_W-1:0] addr_q
);

  localparam int IDX_W  = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam int LOAD_W = ADDR_NIBS * NIB_W;

  logic [ADDR_W-1:0] addr_n;
  logic              addr_en;

  always_comb begin
    addr_n  = addr_q;
    addr_en = ld_en | inc_en;
    if (ld_en) begin
      addr_n[int'(ld_idx)*NIB_W +: NIB_W] = ld_nib;
      if (ld_last) begin
        for (int i = LOAD_W; i < ADDR_W; i++) addr_n[i] = 1'b0;
      end
    end else if (inc_en) begin
      addr_n = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_n;
  end

endmodule

// File: rtl/nhp_ctrl.sv
module nhp_ctrl
  import nhp_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  nhp_cmd_e           cmd_s,
  input  logic [NIB_W-1:0]   nib_s,
  input  logic               toggle,
  input  logic               cmd_chg,
  input  logic [2*NIB_W-1:0] rdata,
  output logic               ld_en,
  output logic [IDX_W-1:0]   ld_idx,
  output logic               ld_last,
  output logic               inc_en,
  output logic               mem_we,
  output logic               mem_oe,
  output logic               busy,
  output logic [2*NIB_W-1:0] wdata,
  output logic [NIB_W-1:0]   nib_out
);

  localparam int IDX_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam int BYTE_W = 2 * NIB_W;

  nhp_state_e        state_q, state_n;
  logic [IDX_W-1:0]  cnt_q, cnt_n;
  logic              hi_q, hi_n;
  logic [NIB_W-1:0]  lo_q;
  logic [BYTE_W-1:0] wbyte_q, rbuf_q;
  logic              lo_en, wb_en, rb_en;
  logic              take;

  assign take = toggle && (state_q == ST_IDLE) && !cmd_chg;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    hi_n    = hi_q;
    lo_en   = 1'b0;
    wb_en   = 1'b0;
    rb_en   = 1'b0;
    ld_en   = 1'b0;
    ld_last = 1'b0;
    inc_en  = 1'b0;
    ld_idx  = cnt_q;

    case (state_q)
      ST_WRITE: begin
        state_n = ST_IDLE;
        inc_en  = 1'b1;
      end
      ST_FETCH: begin
        state_n = ST_IDLE;
        rb_en   = 1'b1;
      end
      default: ;
    endcase

    if (cmd_chg) begin
      cnt_n = '0;
      hi_n  = 1'b0;
    end else if (take) begin
      case (cmd_s)
        CMD_ADDR: begin
          ld_en   = 1'b1;
          ld_last = (cnt_q == IDX_W'(ADDR_NIBS - 1));
          cnt_n   = ld_last ? '0 : cnt_q + IDX_W'(1);
        end
        CMD_WRITE: begin
          if (cnt_q == '0) begin
            lo_en = 1'b1;
            cnt_n = IDX_W'(1);
          end else begin
            wb_en   = 1'b1;
            cnt_n   = '0;
            state_n = ST_WRITE;
          end
        end
        CMD_READ: begin
          if (cnt_q == '0) begin
            state_n = ST_FETCH;
            hi_n    = 1'b0;
            cnt_n   = IDX_W'(1);
          end else begin
            hi_n   = 1'b1;
            cnt_n  = '0;
            inc_en = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      hi_q    <= hi_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= nib_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wbyte_q <= '0;
    else if (wb_en) wbyte_q <= {nib_s, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rbuf_q <= '0;
    else if (rb_en) rbuf_q <= rdata;
  end

  assign mem_we  = (state_q == ST_WRITE);
  assign mem_oe  = (state_q == ST_FETCH);
  assign busy    = (state_q != ST_IDLE);
  assign wdata   = wbyte_q;
  assign nib_out = hi_q ? rbuf_q[BYTE_W-1:NIB_W] : rbuf_q[NIB_W-1:0];

endmodule

// File: rtl/nhp_host_port.sv
module nhp_host_port
  import nhp_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int ADDR_NIBS   = 4,
  parameter int ADDR_W      = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cmd_i,
  input  logic                strobe_i,
  input  logic [NIB_W-1:0]    nib_i,
  output logic [NIB_W-1:0]    nib_o,
  output logic                nib_oe,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [2*NIB_W-1:0]  mem_wdata_o,
  input  logic [2*NIB_W-1:0]  mem_rdata_i,
  output logic                mem_we_o,
  output logic                mem_oe_o,
  output logic                busy_o
);

  localparam int IDX_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;

  logic             rst_int_n;
  nhp_cmd_e         cmd_s;
  logic [NIB_W-1:0] nib_s;
  logic             toggle, cmd_chg;
  logic             ld_en, ld_last, inc_en;
  logic [IDX_W-1:0] ld_idx;

  nhp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  nhp_front #(.NIB_W(NIB_W), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd_i    (cmd_i),
    .strobe_i (strobe_i),
    .nib_i    (nib_i),
    .cmd_s    (cmd_s),
    .nib_s    (nib_s),
    .toggle   (toggle),
    .cmd_chg  (cmd_chg)
  );

  nhp_ctrl #(.NIB_W(NIB_W), .ADDR_NIBS(ADDR_NIBS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cmd_s   (cmd_s),
    .nib_s   (nib_s),
    .toggle  (toggle),
    .cmd_chg (cmd_chg),
    .rdata   (mem_rdata_i),
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .ld_last (ld_last),
    .inc_en  (inc_en),
    .mem_we  (mem_we_o),
    .mem_oe  (mem_oe_o),
    .busy    (busy_o),
    .wdata   (mem_wdata_o),
    .nib_out (nib_o)
  );

  nhp_addr #(.NIB_W(NIB_W), .ADDR_NIBS(ADDR_NIBS), .ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .ld_nib  (nib_s),
    .ld_last (ld_last),
    .inc_en  (inc_en),
    .addr_q  (mem_addr_o)
  );

  assign nib_oe = (cmd_s == CMD_READ);

endmodule

// File: rtl/nhp_checker.sv
module nhp_checker #(
  parameter int ADDR_W      = 17,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_i,
  input logic              nib_oe,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_oe_o,
  input logic              busy_o
);

  AST_WE_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o); // R4

  AST_WE_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o); // R4

  AST_ADDR_STEP_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (mem_addr_o == ADDR_W'($past(mem_addr_o) + ADDR_W'(1)))); // R5

  AST_FETCH_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_o |=> !mem_oe_o); // R6

  AST_NO_WE_OE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_oe_o)); // R6

  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    nib_oe |-> ($past(cmd_i, SYNC_STAGES) == 2'b11)); // R7

endmodule

bind nhp_host_port nhp_checker #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/nhp_host_port_test.sv
module nhp_host_port_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cmd_i;
  logic        strobe_i;
  logic [3:0]  nib_i;
  logic [3:0]  nib_o;
  logic        nib_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, mem_oe, busy;
  logic        init_req;
  logic [7:0]  mem [256];

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  nhp_host_port uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .strobe_i    (strobe_i),
    .nib_i       (nib_i),
    .nib_o       (nib_o),
    .nib_oe      (nib_oe),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_we_o    (mem_we),
    .mem_oe_o    (mem_oe),
    .busy_o      (busy)
  );

  function automatic logic [7:0] init_byte(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_byte(8'(i));
    end else if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  assign mem_rdata = mem[mem_addr[7:0]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [3:0] n);
    if (cmd_i !== c) begin
      cmd_i = c;
      repeat (4) @(negedge clk);
    end
    nib_i    = n;
    strobe_i = ~strobe_i;
    repeat (5) @(negedge clk);
  endtask

  task automatic quick(input logic [3:0] n);
    nib_i    = n;
    strobe_i = ~strobe_i;
    repeat (3) @(negedge clk);
  endtask

  // {cmd[1:0], nibble[3:0], nibble check[1:0], expected address[16:0]}
  // nibble check: 0 none, 1 low half of byte at address, 2 high half of byte at address-1
  localparam logic [24:0] TBL [16] = '{
    {2'b01, 4'hF, 2'd0, 17'h0000F},
    {2'b01, 4'hE, 2'd0, 17'h000EF},
    {2'b01, 4'hD, 2'd0, 17'h00DEF},
    {2'b01, 4'hC, 2'd0, 17'h0CDEF},
    {2'b10, 4'h1, 2'd0, 17'h0CDEF},
    {2'b10, 4'h2, 2'd0, 17'h0CDF0},
    {2'b10, 4'h3, 2'd0, 17'h0CDF0},
    {2'b10, 4'h4, 2'd0, 17'h0CDF1},
    {2'b01, 4'h7, 2'd0, 17'h0CDF7},
    {2'b01, 4'h6, 2'd0, 17'h0CD67},
    {2'b01, 4'h5, 2'd0, 17'h0C567},
    {2'b01, 4'h4, 2'd0, 17'h04567},
    {2'b11, 4'h0, 2'd1, 17'h04567},
    {2'b11, 4'h0, 2'd2, 17'h04568},
    {2'b11, 4'h0, 2'd1, 17'h04568},
    {2'b11, 4'h0, 2'd2, 17'h04569}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    cmd_i    = 2'b00;
    strobe_i = 1'b0;
    nib_i    = 4'h0;
    init_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 we in reset", 32'(mem_we), 0);
    chk("R1 busy in reset", 32'(busy), 0);
    init_req = 1'b0;
    rst_n    = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 addr after reset", 32'(mem_addr), 0);
    chk("R1 oe after reset", 32'(mem_oe), 0);
    chk("R1 drive after reset", 32'(nib_oe), 0);

    // table walk: R2 address loading, R3/R5 writes, R6 reads, R8 cmd change
    for (int i = 0; i < 16; i++) begin
      logic [1:0]  c;
      logic [3:0]  n;
      logic [1:0]  k;
      logic [16:0] ea;
      logic [7:0]  b;
      {c, n, k, ea} = TBL[i];
      step(c, n);
      case (c)
        2'b01:   chk("R2 address load", 32'(mem_addr), 32'(ea));
        2'b10:   chk("R5 write address", 32'(mem_addr), 32'(ea));
        default: chk("R6 read address", 32'(mem_addr), 32'(ea));
      endcase
      if (k == 2'd1) begin
        b = init_byte(ea[7:0]);
        chk("R6 low nibble", 32'(nib_o), 32'(b[3:0]));
        chk("R7 drive in read", 32'(nib_oe), 1);
      end else if (k == 2'd2) begin
        b = init_byte(8'(ea[7:0] - 8'd1));
        chk("R6 high nibble", 32'(nib_o), 32'(b[7:4]));
      end
    end
    chk("R3 first byte", 32'(mem[8'hEF]), 32'h21);
    chk("R5 second byte", 32'(mem[8'hF0]), 32'h43);

    // R4 strobe timing and R5 carry into bit 16
    step(2'b01, 4'hF); step(2'b01, 4'hF); step(2'b01, 4'hF); step(2'b01, 4'hF);
    chk("R2 load ffff", 32'(mem_addr), 32'h0FFFF);
    step(2'b10, 4'hC);
    chk("R7 no drive in write", 32'(nib_oe), 0);
    nib_i    = 4'h5;
    strobe_i = ~strobe_i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 we high", 32'(mem_we), 1);
    chk("R4 busy high", 32'(busy), 1);
    @(negedge clk);
    chk("R4 we low after one clock", 32'(mem_we), 0);
    chk("R4 busy low after one clock", 32'(busy), 0);
    chk("R5 carry into bit 16", 32'(mem_addr), 32'h10000);
    repeat (2) @(negedge clk);
    chk("R3 byte at ff", 32'(mem[8'hFF]), 32'h5C);

    // R2 fourth nibble clears bit 16
    step(2'b01, 4'h4); step(2'b01, 4'h3); step(2'b01, 4'h2); step(2'b01, 4'h1);
    chk("R2 bit 16 cleared", 32'(mem_addr), 32'h01234);

    // R8 a command change drops a held low half
    step(2'b10, 4'h9);
    cmd_i = 2'b01;
    repeat (4) @(negedge clk);
    step(2'b10, 4'h7);
    step(2'b10, 4'h8);
    chk("R8 fresh byte", 32'(mem[8'h34]), 32'h87);
    chk("R8 address after", 32'(mem_addr), 32'h01235);

    // R9 idle ignores toggles
    step(2'b00, 4'hB);
    step(2'b00, 4'hA);
    chk("R9 address unchanged", 32'(mem_addr), 32'h01235);
    chk("R9 memory unchanged", 32'(mem[8'h35]), 32'(init_byte(8'h35)));
    chk("R7 no drive in idle", 32'(nib_oe), 0);

    // R10 burst with three-clock spacing
    step(2'b01, 4'h0); step(2'b01, 4'h4); step(2'b01, 4'h0); step(2'b01, 4'h0);
    chk("R2 load 0040", 32'(mem_addr), 32'h00040);
    cmd_i = 2'b10;
    repeat (4) @(negedge clk);
    for (int j = 1; j <= 4; j++) begin
      quick(4'(j));
      quick(4'(j));
    end
    repeat (4) @(negedge clk);
    for (int j = 0; j < 4; j++)
      chk("R10 burst byte", 32'(mem[8'(8'h40 + j)]), 32'({4'(j + 1), 4'(j + 1)}));
    chk("R10 burst address", 32'(mem_addr), 32'h00044);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule